// File: doc/BRIEF.md
# SPI Register Initialization Sequencer

This block brings up an SPI-controlled RF transceiver after power-on. A synthesizable constant program lists the steps. Each step is one of four kinds: a register write, a read that checks an identity value, a wait of some milliseconds, or a repeated read of a calibration status bit that has a time limit. After a start pulse the sequencer works through the program in order. It issues each register access to a separate SPI shifter with a request/acknowledge handshake, and the shifter returns a read byte with the acknowledge.

The program gives the device's required first write. It then enables the clocks and waits 20 ms. It loads the PLL frequency word with the fractional bytes before the integer byte, and pulses the calibration start bit. Last, it waits for calibration lock, with a 2000 ms limit. A free-running prescaler, cleared at every step change, produces a one-millisecond tick that drives both the wait and the time limit. The block also exports the SPI clock divider, raised when needed so that the serial clock never goes above 20 MHz.

Top module: `spi_init_seq`

## Requirements
- R1: While reset is held, busy, done, err and spi_req are 0, and err_code is 0.
- R2: A start pulse while idle or halted begins the program at its first step. busy is 1 from the cycle after start until the run ends. done pulses for exactly one cycle, two cycles after the acknowledge of the final calibration read, and only when no error occurred. A start pulse while busy has no effect.
- R3: SPI transactions run in program order. The first is a write of 0x01 to address 0x3DF. The clock-enable write (0x07 to 0x009) comes before the delay. The frequency bytes go to 0x043, 0x042 and 0x041, then to 0x044. Calibration start writes 0x05 to 0x03F and then 0x01 to 0x03F.
- R4: spi_rd is 1 for reads and 0 for writes. spi_req, spi_addr and spi_rd hold steady until spi_ack, and spi_rdata is taken in the acknowledge cycle.
- R5: The identity step reads address 0x037 and expects 0x0A. On a mismatch the sequencer halts with err=1 and err_code=1, and it issues no further requests.
- R6: After the clock-enable write is acknowledged, no request is issued for exactly 20 × TICKS_PER_MS cycles.
- R7: The calibration step reads 0x05E again and again. It moves on only when bit 7 of the returned byte is 1, and other set bits do not count.
- R8: If bit 7 is not seen within 2000 ms, the sequencer halts with err=1 and err_code=2. err is first visible exactly 2000 × TICKS_PER_MS cycles after the first calibration request is seen.
- R9: spi_clk_div equals SCLK_DIV, raised to ceil(SYS_CLK_KHZ / 20000) when SCLK_DIV is smaller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for the program |
| spi_req | output | 1 | Transaction request to the SPI shifter |
| spi_rd | output | 1 | 1 = read, 0 = write |
| spi_addr | output | 10 | Register address |
| spi_wdata | output | 8 | Write byte |
| spi_ack | input | 1 | Transaction complete |
| spi_rdata | input | 8 | Read byte, valid with spi_ack |
| spi_clk_div | output | 8 | Serial clock divider for the shifter |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | Halted on an error |
| err_code | output | 2 | 0 none, 1 identity mismatch, 2 calibration timeout |

## Verification
The bench returns 0x7F on calibration reads before it returns 0x80. A design that tested any set bit instead of bit 7 would leave the step too early, and the transaction order would break. The wait and the timeout are each measured to the exact cycle, so a prescaler that is off by one, or a counter that is not cleared at step change, shows up as a cycle error. A restart from the halted state without a reset catches error codes that stick. A second start during the delay catches a sequencer that restarts its program while busy.

// File: rtl/spi_init_pkg.sv
package spi_init_pkg;

    localparam int unsigned ADDR_W       = 10;
    localparam int unsigned DATA_W       = 8;
    localparam int unsigned MS_W         = 12;
    localparam int unsigned PROG_LEN     = 14;
    localparam int unsigned PC_W         = $clog2(PROG_LEN);
    localparam int unsigned SCLK_MAX_KHZ = 20000;

    typedef enum logic [2:0] {
        OP_WRITE,
        OP_IDCHK,
        OP_DELAY,
        OP_POLL,
        OP_END
    } op_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_ID   = 2'd1,
        ERR_CAL  = 2'd2
    } err_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;   // write byte, expected id, or poll mask
        logic [MS_W-1:0]   ms;     // delay length or poll time limit
    } cmd_t;

    function automatic cmd_t mk(op_e op, logic [ADDR_W-1:0] a,
                                logic [DATA_W-1:0] d, logic [MS_W-1:0] ms);
        cmd_t c;
        c.op = op; c.addr = a; c.data = d; c.ms = ms;
        return c;
    endfunction

    // Power-up program; order of entries is behaviour.
    function automatic cmd_t prog_entry(logic [PC_W-1:0] idx);
        case (idx)
            4'd0:    return mk(OP_WRITE, 10'h3DF, 8'h01, 12'd0);
            4'd1:    return mk(OP_IDCHK, 10'h037, 8'h0A, 12'd0);
            4'd2:    return mk(OP_WRITE, 10'h2A6, 8'h0E, 12'd0);
            4'd3:    return mk(OP_WRITE, 10'h2A8, 8'h0E, 12'd0);
            4'd4:    return mk(OP_WRITE, 10'h009, 8'h07, 12'd0);
            4'd5:    return mk(OP_DELAY, 10'h000, 8'h00, 12'd20);
            4'd6:    return mk(OP_WRITE, 10'h043, 8'h29, 12'd0);
            4'd7:    return mk(OP_WRITE, 10'h042, 8'h5C, 12'd0);
            4'd8:    return mk(OP_WRITE, 10'h041, 8'h12, 12'd0);
            4'd9:    return mk(OP_WRITE, 10'h044, 8'h18, 12'd0);
            4'd10:   return mk(OP_WRITE, 10'h03F, 8'h05, 12'd0);
            4'd11:   return mk(OP_WRITE, 10'h03F, 8'h01, 12'd0);
            4'd12:   return mk(OP_POLL,  10'h05E, 8'h80, 12'd2000);
            default: return mk(OP_END,   10'h000, 8'h00, 12'd0);
        endcase
    endfunction

    function automatic int unsigned min_div(int unsigned sys_khz);
        return (sys_khz + SCLK_MAX_KHZ - 1) / SCLK_MAX_KHZ;
    endfunction

endpackage

// File: rtl/spi_init_rom.sv
module spi_init_rom
    import spi_init_pkg::*;
(
    input  logic [PC_W-1:0] pc,
    output cmd_t            cmd
);
    assign cmd = prog_entry(pc);
endmodule

// File: rtl/spi_init_tick.sv
module spi_init_tick #(
    parameter int unsigned TICKS_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    if (TICKS_PER_MS < 2) begin : g_direct
        logic unused_in;
        assign unused_in = clk ^ rst ^ clr;
        assign tick      = 1'b1;
    end else begin : g_count
        localparam int unsigned CW = $clog2(TICKS_PER_MS);
        localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MS - 1);
        logic [CW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst || clr)      cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
        end

        assign tick = (cnt == LAST);

        AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick);  // R6
    end
endmodule

// File: rtl/spi_init_seq.sv
module spi_init_seq
    import spi_init_pkg::*;
#(
    parameter int unsigned SYS_CLK_KHZ  = 100000,
    parameter int unsigned SCLK_DIV     = 2,
    parameter int unsigned TICKS_PER_MS = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              spi_req,
    output logic              spi_rd,
    output logic [ADDR_W-1:0] spi_addr,
    output logic [DATA_W-1:0] spi_wdata,
    input  logic              spi_ack,
    input  logic [DATA_W-1:0] spi_rdata,
    output logic [7:0]        spi_clk_div,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code
);
    localparam int unsigned MIN_DIV = min_div(SYS_CLK_KHZ);
    localparam int unsigned EFF_DIV = (SCLK_DIV < MIN_DIV) ? MIN_DIV : SCLK_DIV;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HALT} state_e;

    state_e          state;
    logic [PC_W-1:0] pc;
    logic [MS_W-1:0] ms_cnt;
    err_e            code_q;
    cmd_t            cmd;
    logic            tick, clr, launch;
    logic            advance, fail, finish, last_ms;
    err_e            fail_code;

    spi_init_rom u_rom (.pc(pc), .cmd(cmd));

    spi_init_tick #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
        .clk(clk), .rst(rst), .clr(clr), .tick(tick)
    );

    assign launch  = (state != ST_RUN) && start;
    assign clr     = launch || advance;
    assign last_ms = tick && (ms_cnt == cmd.ms - 12'd1);

    always_comb begin
        advance   = 1'b0;
        fail      = 1'b0;
        finish    = 1'b0;
        fail_code = ERR_NONE;
        if (state == ST_RUN) begin
            unique case (cmd.op)
                OP_WRITE: advance = spi_ack;
                OP_IDCHK: begin
                    if (spi_ack && spi_rdata == cmd.data) advance = 1'b1;
                    else if (spi_ack) begin
                        fail = 1'b1; fail_code = ERR_ID;
                    end
                end
                OP_DELAY: advance = last_ms;
                OP_POLL: begin
                    if (spi_ack && (spi_rdata & cmd.data) != '0) advance = 1'b1;
                    else if (last_ms) begin
                        fail = 1'b1; fail_code = ERR_CAL;
                    end
                end
                default:  finish = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pc     <= '0;
            ms_cnt <= '0;
            code_q <= ERR_NONE;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                state  <= ST_RUN;
                pc     <= '0;
                ms_cnt <= '0;
                code_q <= ERR_NONE;
            end else if (state == ST_RUN) begin
                if (finish) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end else if (fail) begin
                    state  <= ST_HALT;
                    code_q <= fail_code;
                end else if (advance) begin
                    pc     <= pc + 1'b1;
                    ms_cnt <= '0;
                end else if (tick) begin
                    ms_cnt <= ms_cnt + 1'b1;
                end
            end
        end
    end

    assign spi_req     = (state == ST_RUN) &&
                         (cmd.op == OP_WRITE || cmd.op == OP_IDCHK || cmd.op == OP_POLL);
    assign spi_rd      = (cmd.op != OP_WRITE);
    assign spi_addr    = cmd.addr;
    assign spi_wdata   = cmd.data;
    assign spi_clk_div = 8'(EFF_DIV);
    assign busy        = (state == ST_RUN);
    assign err         = (code_q != ERR_NONE);
    assign err_code    = code_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        spi_req && !spi_ack |=> (spi_req && $stable(spi_addr) && $stable(spi_rd)) || err);  // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R2
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        done |-> !err && !busy);  // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !spi_req);  // R2
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        err |-> !spi_req && !done);  // R5
    AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> spi_req && !spi_rd && spi_addr == 10'h3DF && spi_wdata == 8'h01);  // R3
endmodule

// File: tb/test_spi_init_seq.sv
module test_spi_init_seq;
    localparam int CLK_PERIOD  = 10;
    localparam int TPM         = 20;
    localparam int LAT         = 2;
    localparam int DELAY_CYC   = 20 * TPM;
    localparam int TIMEOUT_CYC = 2000 * TPM;
    localparam int NEXP        = 12;

    logic       clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic       spi_ack = 1'b0;
    logic [7:0] spi_rdata = 8'h00;
    logic       spi_req, spi_rd, busy, done, err;
    logic [9:0] spi_addr;
    logic [7:0] spi_wdata, spi_clk_div;
    logic [1:0] err_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_init_seq #(.SYS_CLK_KHZ(100000), .SCLK_DIV(2), .TICKS_PER_MS(TPM)) i_spi_init_seq (
        .clk(clk), .rst(rst), .start(start),
        .spi_req(spi_req), .spi_rd(spi_rd), .spi_addr(spi_addr), .spi_wdata(spi_wdata),
        .spi_ack(spi_ack), .spi_rdata(spi_rdata), .spi_clk_div(spi_clk_div),
        .busy(busy), .done(done), .err(err), .err_code(err_code)
    );

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    // reference program of SPI transactions
    bit         exp_rd[NEXP];
    bit         exp_poll[NEXP];
    logic [9:0] exp_addr[NEXP];
    logic [7:0] exp_dat[NEXP];

    task automatic put(input int i, input bit rd, input bit poll, input logic [9:0] a, input logic [7:0] d);
        exp_rd[i] = rd; exp_poll[i] = poll; exp_addr[i] = a; exp_dat[i] = d;
    endtask

    // model state
    bit   mb, st_q, end_ok, delay_arm, poll_seen, saw_done;
    int   idx, end_cd, gap, slave_cnt, poll_reads, cal_after, cyc;
    logic [1:0] end_code, exp_code;
    logic [7:0] id_value;

    always @(posedge clk) st_q <= start && !rst;

    always @(negedge clk) begin : model
        bit exp_done;
        exp_done = 1'b0;
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL R2 watchdog: actual %0d expected below 190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
        if (rst) begin
            mb = 0; exp_code = 0; end_cd = 0; spi_ack = 0; slave_cnt = 0; delay_arm = 0;
        end else begin
            if (mb && end_cd > 0) begin
                end_cd--;
                if (end_cd == 0) begin
                    mb = 0; exp_done = end_ok; exp_code = end_code;
                end
            end
            if (!mb && st_q) begin
                mb = 1; idx = 0; exp_code = 0; poll_reads = 0; poll_seen = 0;
                delay_arm = 0; slave_cnt = 0; saw_done = 0;
            end
            if (done) saw_done = 1;
            chk(busy === mb, "R2", "busy", busy, mb);
            chk(done === exp_done, "R2", "done", done, exp_done);
            chk(err_code === exp_code, "R5,R8", "err_code", err_code, exp_code);
            chk(err === (exp_code != 0), "R5,R8", "err", err, exp_code != 0);
            if (spi_req && !mb) chk(0, "R5", "request while stopped", 1, 0);
            // R6 delay window
            if (delay_arm) begin
                if (spi_req) begin
                    chk(gap == DELAY_CYC, "R6", "delay gap", gap, DELAY_CYC);
                    delay_arm = 0;
                end else gap++;
            end
            // R8 timeout window starts at the first calibration request
            if (mb && spi_req && spi_addr == 10'h05E && !poll_seen) begin
                poll_seen = 1;
                if (cal_after < 0) begin
                    end_cd = TIMEOUT_CYC; end_ok = 0; end_code = 2;
                end
            end
            // SPI slave
            if (spi_ack) spi_ack = 0;
            else if (spi_req) begin
                slave_cnt++;
                if (slave_cnt >= LAT) begin
                    slave_cnt = 0;
                    spi_ack   = 1;
                    if (idx >= NEXP) chk(0, "R3", "extra transaction", idx, NEXP);
                    else begin
                        chk(spi_rd === exp_rd[idx], "R4", "read flag", spi_rd, exp_rd[idx]);
                        chk(spi_addr === exp_addr[idx], "R3", "address", spi_addr, exp_addr[idx]);
                        if (!exp_rd[idx])
                            chk(spi_wdata === exp_dat[idx], "R3", "write byte", spi_wdata, exp_dat[idx]);
                        if (exp_poll[idx]) begin
                            if (cal_after >= 0 && poll_reads >= cal_after) begin
                                spi_rdata = 8'h80; idx++;
                                end_cd = 2; end_ok = 1; end_code = 0;
                            end else spi_rdata = 8'h7F;   // R7: bit 7 clear, others set
                            poll_reads++;
                        end else if (exp_rd[idx]) begin
                            spi_rdata = id_value;
                            if (id_value != 8'h0A) begin
                                end_cd = 1; end_ok = 0; end_code = 1;
                            end
                            idx++;
                        end else begin
                            if (spi_addr == 10'h009) begin delay_arm = 1; gap = 0; end
                            idx++;
                        end
                    end
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end(input int limit);
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        while (mb && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (n >= limit) chk(0, "R2", "run did not end", n, limit);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        put(0, 0, 0, 10'h3DF, 8'h01);  put(1, 1, 0, 10'h037, 8'h00);
        put(2, 0, 0, 10'h2A6, 8'h0E);  put(3, 0, 0, 10'h2A8, 8'h0E);
        put(4, 0, 0, 10'h009, 8'h07);  put(5, 0, 0, 10'h043, 8'h29);
        put(6, 0, 0, 10'h042, 8'h5C);  put(7, 0, 0, 10'h041, 8'h12);
        put(8, 0, 0, 10'h044, 8'h18);  put(9, 0, 0, 10'h03F, 8'h05);
        put(10, 0, 0, 10'h03F, 8'h01); put(11, 1, 1, 10'h05E, 8'h00);
        id_value  = 8'h0A;
        cal_after = 3;

        // R1 reset state, R9 divider
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1", "status in reset", {busy, done, err}, 0);
        chk(spi_req === 1'b0, "R1", "request in reset", spi_req, 0);
        chk(err_code === 2'd0, "R1", "err_code in reset", err_code, 0);
        chk(spi_clk_div === 8'd5, "R9", "clock divider", spi_clk_div, 5);
        rst = 1'b0;

        // Run 1: full success, extra start during delay
        pulse_start();
        repeat (150) @(negedge clk);
        pulse_start();
        wait_end(5000);
        chk(idx == NEXP, "R3", "program completed", idx, NEXP);
        chk(poll_reads == 4, "R7", "calibration reads", poll_reads, 4);
        chk(saw_done, "R2", "done seen", saw_done, 1);
        chk(!delay_arm, "R6", "delay measured", delay_arm, 0);

        // Run 2: identity mismatch
        do_reset();
        id_value = 8'h55;
        pulse_start();
        wait_end(5000);
        repeat (20) @(negedge clk);
        chk(err_code === 2'd1, "R5", "id mismatch code", err_code, 1);
        chk(idx == 2, "R5", "stops after id read", idx, 2);
        chk(!saw_done, "R5", "no done", saw_done, 0);

        // Run 3: calibration never locks
        do_reset();
        id_value  = 8'h0A;
        cal_after = -1;
        pulse_start();
        wait_end(TIMEOUT_CYC + 5000);
        chk(err_code === 2'd2, "R8", "timeout code", err_code, 2);
        chk(poll_reads > 1, "R7", "repeated reads", poll_reads, 2);
        chk(idx == NEXP - 1, "R8", "halted at poll", idx, NEXP - 1);

        // Run 4: restart from halt without reset, immediate lock
        cal_after = 0;
        pulse_start();
        wait_end(5000);
        chk(err_code === 2'd0, "R2", "error cleared on restart", err_code, 0);
        chk(saw_done, "R2", "done after restart", saw_done, 1);
        chk(idx == NEXP, "R7", "lock on first read", idx, NEXP);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule